// File: doc/BRIEF.md
# Section Address Translator with TLB and Table Walker

This block turns 32-bit virtual addresses into physical addresses. The mapping is a single-level table in memory with one descriptor per 1 MB section. The top twelve address bits pick the descriptor, and the low twenty bits pass through unchanged. A small fully associative translation cache holds recently used section mappings. On a hit the result comes back one cycle after the request is accepted, and memory is not touched.

On a miss a hardware walker forms the descriptor address and issues one read on a valid/ready memory port. When the data returns, the walker answers the request. If the descriptor is a valid section, the walker also stores the mapping in the cache slot named by a round-robin pointer.

A single enable input switches translation off, and the address then passes straight through. A one-cycle invalidate input empties the cache. Only one translation is in flight at any time.

Top module: `sect_mmu`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_valid is 0, and every cache entry is invalid, so the first enabled translation of any address issues a memory read.
- R2: The descriptor read address is (tbl_base AND 0xFFFFC000) OR (va[31:20] shifted left by 2). The base is sampled in the cycle the miss is accepted.
- R3: With xlat_en at 1, a request whose va[31:20] matches a valid cached entry is answered in the cycle after acceptance, with pa = {cached section bits, va[19:0]}, rsp_fault 0, and no memory read.
- R4: On a miss, exactly one descriptor read is issued. The answer comes in the cycle after mem_rsp_valid, with pa = {data[31:20], va[19:0]} and rsp_fault 0.
- R5: A descriptor is a section only when data[1:0] equals 2'b10. Any other value gives rsp_fault 1 with rsp_pa 0 and is not cached, so a repeat of the same address reads memory again.
- R6: With xlat_en at 0, an accepted request is answered in the next cycle with rsp_pa equal to req_va and rsp_fault 0. No lookup and no read take place.
- R7: A tlb_flush pulse invalidates every entry. A request accepted in the same cycle as the pulse is still looked up against the contents from before the pulse.
- R8: Fills go to slots 0, 1, …, N-1 and then wrap to 0. Fault responses and discarded fills do not advance the pointer.
- R9: req_ready is 0 from the cycle after a miss is accepted until the cycle its response appears. Requests presented in that window are ignored.
- R10: A tlb_flush during a walk does not disturb the response of that walk, but the fetched mapping is not cached.
- R11: mem_rd_valid stays high, with mem_rd_addr unchanged, until mem_rd_ready is seen.
- R12: Every accepted request produces exactly one rsp_valid pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | 1: translate; 0: physical equals virtual |
| tbl_base | input | 32 | Table base address; low 14 bits are ignored |
| tlb_flush | input | 1 | One-cycle invalidate of all cache entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Descriptor was not a section |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
The bench builds the block with four cache entries instead of the default eight. This lets a handful of distinct sections wrap the round-robin pointer, so eviction of the oldest fill and its later refill into the next slot can be checked within a short run. The table base is deliberately unaligned, which exercises the masking of the descriptor address. The memory model stalls its ready signal in a fixed pattern, which exercises the hold behaviour of the read request.

// File: rtl/sect_mmu_pkg.sv
// Shared types and constants for the section address translator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sect_mmu_pkg;

    // Walker sequencing states
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FETCH = 2'd1,
        WALK_WAIT  = 2'd2
    } walk_state_e;

    // Descriptor type code for a 1 MB section
    localparam logic [1:0] DESC_SECTION = 2'b10;

endpackage

// File: rtl/sect_tlb_array.sv
// Fully associative store of section mappings.
// Compares a virtual tag with every valid entry in parallel and fills
// entries in round-robin order. Assumes no tag is ever filled twice
// while still valid; the controller only fills after a miss.
module sect_tlb_array #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lkp_vtag,
    output logic             lkp_hit,
    output logic [TAG_W-1:0] lkp_ptag,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_vtag,
    input  logic [TAG_W-1:0] fill_ptag
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [TAG_W-1:0]   vtag_q [ENTRIES];
    logic [TAG_W-1:0]   ptag_q [ENTRIES];
    logic [PTR_W-1:0]   ptr_q;

    // Per-entry tag comparators
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vtag_q[g] == lkp_vtag);
    end

    // Merge the matching entry's physical tag (at most one matches)
    always_comb begin
        lkp_ptag = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lkp_ptag = lkp_ptag | ptag_q[i];
        end
    end
    assign lkp_hit = |match;

    // Valid bits and victim pointer; invalidate wins over a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Tag storage written at the victim slot
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && !flush && ptr_q == PTR_W'(i)) begin
                vtag_q[i] <= fill_vtag;
                ptag_q[i] <= fill_ptag;
            end
        end
    end

endmodule

// File: rtl/sect_tlb_ctrl.sv
// Request handling and descriptor walker.
// Answers hits and bypass requests one cycle after acceptance. A miss
// starts one descriptor read. Assumes the memory returns exactly one
// mem_rsp_valid for each accepted read, and none while no read is pending.
module sect_tlb_ctrl
    import sect_mmu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SECT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              tlb_flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_fault,
    input  logic              lkp_hit,
    input  logic [ADDR_W-SECT_W-1:0] lkp_ptag,
    output logic              fill_en,
    output logic [ADDR_W-SECT_W-1:0] fill_vtag,
    output logic [ADDR_W-SECT_W-1:0] fill_ptag,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int TAG_W   = ADDR_W - SECT_W;
    localparam int ALIGN_W = TAG_W + 2;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] addr_q;
    logic              drop_fill_q;
    logic              accept;
    logic              miss_start;
    logic              walk_done;
    logic              desc_ok;
    logic [ADDR_W-1:0] fetch_addr;
    logic              unused_bits;

    assign req_ready  = (state_q == WALK_IDLE);
    assign accept     = req_valid && req_ready;
    assign miss_start = accept && xlat_en && !lkp_hit;
    assign walk_done  = (state_q == WALK_WAIT) && mem_rsp_valid;
    assign desc_ok    = (mem_rsp_data[1:0] == DESC_SECTION);
    assign fetch_addr = {tbl_base[ADDR_W-1:ALIGN_W], req_va[ADDR_W-1:SECT_W], 2'b00};
    assign unused_bits = ^{tbl_base[ALIGN_W-1:0], mem_rsp_data[SECT_W-1:2]};

    assign mem_rd_valid = (state_q == WALK_FETCH);
    assign mem_rd_addr  = addr_q;

    assign fill_en   = walk_done && desc_ok && !drop_fill_q && !tlb_flush;
    assign fill_vtag = va_q[ADDR_W-1:SECT_W];
    assign fill_ptag = mem_rsp_data[ADDR_W-1:SECT_W];

    // Walker sequencing: idle -> fetch -> wait -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
        end else begin
            case (state_q)
                WALK_IDLE:  if (miss_start)   state_q <= WALK_FETCH;
                WALK_FETCH: if (mem_rd_ready) state_q <= WALK_WAIT;
                WALK_WAIT:  if (mem_rsp_valid) state_q <= WALK_IDLE;
                default:    state_q <= WALK_IDLE;
            endcase
        end
    end

    // Capture the missing address and its descriptor address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            addr_q <= '0;
        end else if (miss_start) begin
            va_q   <= req_va;
            addr_q <= fetch_addr;
        end
    end

    // Remember an invalidate seen during the walk so the fill is dropped
    always_ff @(posedge clk) begin
        if (!rst_n || miss_start) begin
            drop_fill_q <= 1'b0;
        end else if (tlb_flush && state_q != WALK_IDLE) begin
            drop_fill_q <= 1'b1;
        end
    end

    // Registered response for bypass, hit and walk completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && !xlat_en) begin
                rsp_valid <= 1'b1;
                rsp_pa    <= req_va;
                rsp_fault <= 1'b0;
            end else if (accept && lkp_hit) begin
                rsp_valid <= 1'b1;
                rsp_pa    <= {lkp_ptag, req_va[SECT_W-1:0]};
                rsp_fault <= 1'b0;
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                rsp_pa    <= desc_ok ? {mem_rsp_data[ADDR_W-1:SECT_W], va_q[SECT_W-1:0]} : '0;
                rsp_fault <= !desc_ok;
            end
        end
    end

endmodule

// File: rtl/sect_mmu.sv
// Top of the section address translator: translation cache plus walker.
// Assumes the table base is held stable by software while translation
// is enabled; it is sampled only when a miss starts.
module sect_mmu #(
    parameter int TLB_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int SECT_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              tlb_flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_fault,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int TAG_W = ADDR_W - SECT_W;

    logic             lkp_hit;
    logic [TAG_W-1:0] lkp_ptag;
    logic             fill_en;
    logic [TAG_W-1:0] fill_vtag;
    logic [TAG_W-1:0] fill_ptag;

    sect_tlb_array #(
        .ENTRIES(TLB_ENTRIES),
        .TAG_W  (TAG_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lkp_vtag (req_va[ADDR_W-1:SECT_W]),
        .lkp_hit  (lkp_hit),
        .lkp_ptag (lkp_ptag),
        .flush    (tlb_flush),
        .fill_en  (fill_en),
        .fill_vtag(fill_vtag),
        .fill_ptag(fill_ptag)
    );

    sect_tlb_ctrl #(
        .ADDR_W(ADDR_W),
        .SECT_W(SECT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .xlat_en      (xlat_en),
        .tbl_base     (tbl_base),
        .tlb_flush    (tlb_flush),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_va       (req_va),
        .rsp_valid    (rsp_valid),
        .rsp_pa       (rsp_pa),
        .rsp_fault    (rsp_fault),
        .lkp_hit      (lkp_hit),
        .lkp_ptag     (lkp_ptag),
        .fill_en      (fill_en),
        .fill_vtag    (fill_vtag),
        .fill_ptag    (fill_ptag),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

endmodule

// File: rtl/sect_mmu_checker.sv
// Port-level protocol properties for the section address translator.
// Assumes the memory never returns data while a read is still unaccepted.
module sect_mmu_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xlat_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_va,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_pa,
    input logic              rsp_fault,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid
);
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    assert_busy_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !xlat_en |=> rsp_valid && !rsp_fault && rsp_pa == $past(req_va));

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_pa == '0);

    assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

    assert_walk_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid && !req_ready && !mem_rd_valid |=> rsp_valid);

endmodule

bind sect_mmu sect_mmu_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlat_en      (xlat_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_va       (req_va),
    .rsp_valid    (rsp_valid),
    .rsp_pa       (rsp_pa),
    .rsp_fault    (rsp_fault),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/sect_mmu_test.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module sect_mmu_test;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xlat_en, tlb_flush, req_valid, mem_rd_ready, mem_rsp_valid;
    logic [31:0] tbl_base, req_va, mem_rsp_data;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [31:0] rsp_pa, mem_rd_addr;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    bit done = 0;
    logic [31:0] last_rd_addr;

    always #10 clk = ~clk;

    sect_mmu #(.TLB_ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
        .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Descriptor stored in the table for a given descriptor address
    function automatic logic [31:0] desc_of(input logic [31:0] a);
        int idx;
        idx = int'((a >> 2) & 32'hFFF);
        if (idx % 7 == 5) return (32'(idx) << 20) | 32'h1;
        return ((32'(idx * 37 + 5) & 32'hFFF) << 20) | 32'h0000_0C02;
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va);
        int idx;
        idx = int'(va[31:20]);
        return ((32'(idx * 37 + 5) & 32'hFFF) << 20) | {12'h0, va[19:0]};
    endfunction

    // Memory side: record accepted reads, answer two cycles later
    bit          hs_pend = 0;
    logic [31:0] hs_addr;
    always @(negedge clk) begin
        if (rst_n && mem_rd_valid && mem_rd_ready) begin
            reads++;
            last_rd_addr = mem_rd_addr;
            hs_pend = 1;
            hs_addr = mem_rd_addr;
        end
    end

    initial begin
        int lat = 0;
        int cyc = 0;
        logic [31:0] p_addr = '0;
        mem_rd_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        forever begin
            @(posedge clk); #2;
            mem_rsp_valid = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = desc_of(p_addr);
                end
            end
            if (hs_pend) begin
                hs_pend = 0;
                p_addr = hs_addr;
                lat = 2;
            end
            cyc++;
            mem_rd_ready = (cyc % 3 != 1);
        end
    end

    // Reference model, compared and advanced at each falling edge
    int          m_state;
    logic [31:0] m_va, m_addr, m_pa;
    bit          m_drop, m_rv, m_f;
    string       m_kind;
    logic [11:0] m_vt [N];
    bit          m_v [N];
    int          m_rr;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_rv = 0; m_pa = '0; m_f = 0; m_rr = 0; m_drop = 0;
            m_kind = "R12";
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else begin
            bit hit;
            logic [11:0] hpt;
            chk({31'h0, req_ready}, {31'h0, m_state == 0}, "R9 req_ready");
            chk({31'h0, mem_rd_valid}, {31'h0, m_state == 1}, "R11 mem_rd_valid");
            if (m_state == 1) chk(mem_rd_addr, m_addr, "R2 mem_rd_addr");
            chk({31'h0, rsp_valid}, {31'h0, m_rv}, "R12 rsp_valid");
            if (m_rv) begin
                chk(rsp_pa, m_pa, {m_kind, " rsp_pa"});
                chk({31'h0, rsp_fault}, {31'h0, m_f}, {m_kind, " rsp_fault"});
            end
            m_rv = 0;
            case (m_state)
                0: if (req_valid) begin
                    if (!xlat_en) begin
                        m_rv = 1; m_pa = req_va; m_f = 0; m_kind = "R6";
                    end else begin
                        hit = 0; hpt = '0;
                        for (int i = 0; i < N; i++)
                            if (m_v[i] && m_vt[i] == req_va[31:20]) begin hit = 1; hpt = m_rtag[i]; end
                        if (hit) begin
                            m_rv = 1; m_pa = {hpt, req_va[19:0]}; m_f = 0; m_kind = "R3";
                        end else begin
                            m_state = 1; m_va = req_va; m_drop = 0;
                            m_addr = (tbl_base & 32'hFFFF_C000) | ({20'h0, req_va[31:20]} << 2);
                        end
                    end
                end
                1: begin
                    if (tlb_flush) m_drop = 1;
                    if (mem_rd_ready) m_state = 2;
                end
                default: begin
                    if (tlb_flush) m_drop = 1;
                    if (mem_rsp_valid) begin
                        m_rv = 1; m_state = 0;
                        if (mem_rsp_data[1:0] == 2'b10) begin
                            m_pa = {mem_rsp_data[31:20], m_va[19:0]}; m_f = 0; m_kind = "R4";
                            if (!m_drop && !tlb_flush) begin
                                m_vt[m_rr] = m_va[31:20];
                                m_rtag[m_rr] = mem_rsp_data[31:20];
                                m_v[m_rr] = 1;
                                m_rr = (m_rr + 1) % N;
                            end
                        end else begin
                            m_pa = '0; m_f = 1; m_kind = "R5";
                        end
                    end
                end
            endcase
            if (tlb_flush) for (int i = 0; i < N; i++) m_v[i] = 0;
        end
    end
    logic [11:0] m_rtag [N];

    // One translation; mode 1: flush with request, 2: flush after accept, 3: junk request while busy
    task automatic xlate(input logic [31:0] va, input int mode,
                         output logic [31:0] pa, output logic flt, output int delta);
        bit acc;
        int r0;
        r0 = reads;
        @(posedge clk); #2;
        req_valid = 1'b1; req_va = va;
        tlb_flush = (mode == 1);
        do begin
            @(negedge clk); acc = req_ready;
            @(posedge clk); #2;
        end while (!acc);
        req_valid = (mode == 3);
        req_va = va ^ 32'h0010_0000;
        tlb_flush = (mode == 2);
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            @(posedge clk); #2;
            req_valid = 1'b0; tlb_flush = 1'b0;
        end
        pa = rsp_pa; flt = rsp_fault;
        @(posedge clk); #2;
        req_valid = 1'b0; tlb_flush = 1'b0;
        delta = reads - r0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa;
        logic        flt;
        int          d;
        rst_n = 1'b0; xlat_en = 1'b0; tlb_flush = 1'b0; req_valid = 1'b0;
        req_va = '0; tbl_base = 32'h3000_5A7C;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk({31'h0, req_ready}, 32'h1, "R1 reset req_ready");
        chk({31'h0, rsp_valid}, 32'h0, "R1 reset rsp_valid");
        chk({31'h0, mem_rd_valid}, 32'h0, "R1 reset mem_rd_valid");

        xlate(32'h1234_5678, 0, pa, flt, d);
        chk(pa, 32'h1234_5678, "R6 bypass pa");
        chk(32'(d), 0, "R6 bypass no read");

        @(posedge clk); #2 xlat_en = 1'b1;
        xlate(32'h0034_5678, 0, pa, flt, d);
        chk(32'(d), 1, "R1 first lookup misses");
        chk(pa, exp_pa(32'h0034_5678), "R4 walk pa");
        xlate(32'h003F_0000, 0, pa, flt, d);
        chk(32'(d), 0, "R3 hit no read");
        chk(pa, exp_pa(32'h003F_0000), "R3 hit pa");

        xlate(32'h0051_2345, 0, pa, flt, d);
        chk({31'h0, flt}, 32'h1, "R5 fault flag");
        xlate(32'h0051_2345, 0, pa, flt, d);
        chk(32'(d), 1, "R5 fault not cached");

        xlate(32'h00A0_0000, 0, pa, flt, d);
        xlate(32'h00B0_0000, 0, pa, flt, d);
        xlate(32'h00D0_0004, 3, pa, flt, d);
        chk(32'(d), 1, "R9 busy request ignored");
        chk(pa, exp_pa(32'h00D0_0004), "R9 walk result intact");
        xlate(32'h00E0_0000, 0, pa, flt, d);
        xlate(32'h0030_0010, 0, pa, flt, d);
        chk(32'(d), 1, "R8 oldest slot evicted");
        xlate(32'h00B0_0100, 0, pa, flt, d);
        chk(32'(d), 0, "R8 later slot kept");
        xlate(32'h00A0_0100, 0, pa, flt, d);
        chk(32'(d), 1, "R8 refill took next slot");

        @(posedge clk); #2 tlb_flush = 1'b1;
        @(posedge clk); #2 tlb_flush = 1'b0;
        xlate(32'h00D0_0000, 0, pa, flt, d);
        chk(32'(d), 1, "R7 invalidate clears");

        xlate(32'h0140_1111, 2, pa, flt, d);
        chk(pa, exp_pa(32'h0140_1111), "R10 walk result kept");
        xlate(32'h0140_2222, 0, pa, flt, d);
        chk(32'(d), 1, "R10 fill discarded");
        xlate(32'h0140_3333, 1, pa, flt, d);
        chk(32'(d), 0, "R7 same-cycle lookup sees old");
        xlate(32'h0140_4444, 0, pa, flt, d);
        chk(32'(d), 1, "R7 then invalid");

        @(posedge clk); #2 tbl_base = 32'h0123_FFFF;
        xlate(32'hABC0_0010, 0, pa, flt, d);
        chk(last_rd_addr, 32'h0123_EAF0, "R2 masked base address");
        chk(pa, exp_pa(32'hABC0_0010), "R4 walk pa high tag");

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule